// File: doc/BRIEF.md
# Regulator Start-up Sequencer and Fault Latch

This block is the control state machine that sits over a multiphase buck regulator. It brings the converter up in a fixed order. First it waits for both supply rails to clear their undervoltage lockouts. Once the enable input is high it calibrates, then detects phases and configures. After that it raises the gate-driver enable line. If the boot target is zero it waits for a first voltage command over the serial link; otherwise it goes straight on. It then refreshes the bootstrap capacitors and finally ramps the reference through soft start. The ready flag is raised only once normal regulation begins.

While the converter is switching, the block watches comparator flags from the analog side. An overvoltage latches the regulator off with the low-side switches held on and the reference pulled to zero. An overcurrent latches it off with the drivers disabled. The severe overcurrent tier acts at once; the milder tier must persist for a programmable time. Overcurrent is only honoured after the output or the reference has risen far enough to make the current signal meaningful. An undervoltage only withdraws the ready flag. A latched fault and its recorded cause are cleared only by dropping enable or losing a supply. All delays are counted in clock ticks and set by parameters.

Top module: `vr_seq_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, every output is 0, including `fault_cause`.
- R2: The gate-driver enable stays low while either supply flag is low, while enable is low, while `cal_done` is low and while `cfg_done` is low. Calibration has to complete before configuration is accepted.
- R3: If calibration and configuration are already done, `dron_drive` rises exactly EN_DLY_TICKS+1 clock edges after the edge that first samples `en` high.
- R4: After `dron_drive` rises, the block waits for `drv_ok`. If `boot_zero` is high it then waits for a `vid_set` pulse. The bootstrap refresh then lasts BCAP_TICKS+1 edges, after which `pwm_en` rises and soft start begins.
- R5: `vr_ready` stays low throughout soft start and rises on the edge that samples `ss_done` high.
- R6: During soft start only `ov_abs` causes an overvoltage trip and `ov_rel` is ignored. In normal operation either flag trips. On a trip, the next output state is `dron_drive`=1, `force_ls`=1, `ramp_zero`=1, `fault_latched`=1, `pwm_en`=0, `vr_ready`=0 and `fault_cause`=1. Overvoltage wins over a simultaneous overcurrent.
- R7: An armed `ilim150` latches an overcurrent fault on the very edge it is sampled. The outputs are then `fault_latched`=1, `dron_drive`=0, `pwm_en`=0 and `fault_cause`=3.
- R8: An armed `ilim100` trips on the OC_DLY_TICKS-th consecutive edge it is sampled high, giving `fault_cause`=2. A shorter burst has no effect, and a low sample restarts the count.
- R9: Overcurrent flags are ignored until `vout_hi` or `dac_hi` has been sampled high since soft start began. Arming is then sticky until the converter leaves soft start or normal operation.
- R10: `uv` in normal operation drops `vr_ready` on the next edge without latching. `pwm_en` stays high, and `vr_ready` returns once `uv` clears.
- R11: A latched fault holds while `en`, `vcc_ok` and `vin_ok` remain high. Dropping any of them clears `fault_latched`, `fault_cause` and all other outputs on the next edge.
- R12: Outside a latched fault, `en` low or `drv_ok` low after the driver enable was raised returns the block to the disabled state. `dron_drive`, `pwm_en` and `vr_ready` are then 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_ok | input | 1 | Controller supply above lockout |
| vin_ok | input | 1 | Input rail above lockout |
| en | input | 1 | Regulator enable |
| drv_ok | input | 1 | Sensed level of the gate-driver enable line |
| cal_done | input | 1 | Calibration finished |
| cfg_done | input | 1 | Phase detection and configuration finished |
| boot_zero | input | 1 | Programmed boot voltage is zero |
| vid_set | input | 1 | First voltage command received |
| ss_done | input | 1 | Reference ramp reached target |
| ov_abs | input | 1 | Output above absolute overvoltage level |
| ov_rel | input | 1 | Output above reference plus margin |
| uv | input | 1 | Output below reference minus droop minus margin |
| vout_hi | input | 1 | Output above current-limit arming level |
| dac_hi | input | 1 | Reference above current-limit arming level |
| ilim100 | input | 1 | Current above nominal limit |
| ilim150 | input | 1 | Current above severe limit |
| dron_drive | output | 1 | Gate-driver enable drive |
| vr_ready | output | 1 | Output in regulation |
| pwm_en | output | 1 | Phase modulators allowed to switch |
| force_ls | output | 1 | Force all low-side switches on |
| ramp_zero | output | 1 | Request reference ramp to 0 V |
| fault_latched | output | 1 | A latching fault is held |
| fault_cause | output | 2 | 0 none, 1 overvoltage, 2 slow overcurrent, 3 fast overcurrent |

## Verification
Every output is registered from the next-state decode. A flag sampled at one rising edge therefore shows on the outputs right after that edge. The bench drives inputs just after a falling edge and compares all outputs packed into one byte at a later falling edge. The counted windows are checked on both sides of the edge. Driver enable comes EN_DLY_TICKS+1 edges after enable. Switching starts BCAP_TICKS+1 edges after the refresh begins. The slow current trip lands on the OC_DLY_TICKS-th high sample. For each window, the bench compares one edge before the expected change and again on it.

// File: rtl/vr_seq_pkg.sv
package vr_seq_pkg;

  typedef enum logic [3:0] {
    ST_POR, ST_DIS, ST_CAL, ST_CFG, ST_DRV, ST_WVID,
    ST_BCAP, ST_SS, ST_RUN, ST_OVP, ST_OCP
  } seq_state_e;

  typedef enum logic [1:0] {
    FC_NONE = 2'd0,
    FC_OVP  = 2'd1,
    FC_OCS  = 2'd2,
    FC_OCF  = 2'd3
  } fault_cause_e;

endpackage

// File: rtl/vr_seq_timer.sv
module vr_seq_timer #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic done
);
  localparam int unsigned W = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q;

  // saturating up-counter, cleared while the owning state is not active
  always_ff @(posedge clk) begin
    if (rst || clr)      cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + W'(1);
  end

  assign done = (cnt_q == LIM);

endmodule

// File: rtl/vr_seq_ocp.sv
module vr_seq_ocp #(
  parameter int unsigned OC_TICKS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic act,
  input  logic vout_hi,
  input  logic dac_hi,
  input  logic ilim100,
  input  logic ilim150,
  output logic trip_fast,
  output logic trip_slow
);
  localparam int unsigned W = (OC_TICKS < 2) ? 1 : $clog2(OC_TICKS + 1);
  localparam logic [W-1:0] LAST = W'(OC_TICKS - 1);

  logic         arm_q;
  logic         armed;
  logic [W-1:0] cnt_q;

  assign armed = act && (arm_q || vout_hi || dac_hi);

  always_ff @(posedge clk) begin
    if (rst) arm_q <= 1'b0;
    else     arm_q <= armed;
  end

  // consecutive-sample persistence counter for the nominal tier
  always_ff @(posedge clk) begin
    if (rst || !(armed && ilim100)) cnt_q <= '0;
    else if (cnt_q != LAST)         cnt_q <= cnt_q + W'(1);
  end

  assign trip_slow = armed && ilim100 && (cnt_q == LAST);
  assign trip_fast = armed && ilim150;

  generate
    if (OC_TICKS > 1) begin : g_hist
      // R8
      slow_hist_chk: assert property (@(posedge clk) disable iff (rst)
        trip_slow |-> $past(ilim100));
    end
  endgenerate

endmodule

// File: rtl/vr_seq_ctrl.sv
module vr_seq_ctrl
  import vr_seq_pkg::*;
#(
  parameter int unsigned EN_DLY_TICKS = 500_000,
  parameter int unsigned BCAP_TICKS   = 2_000,
  parameter int unsigned OC_DLY_TICKS = 5_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       vcc_ok,
  input  logic       vin_ok,
  input  logic       en,
  input  logic       drv_ok,
  input  logic       cal_done,
  input  logic       cfg_done,
  input  logic       boot_zero,
  input  logic       vid_set,
  input  logic       ss_done,
  input  logic       ov_abs,
  input  logic       ov_rel,
  input  logic       uv,
  input  logic       vout_hi,
  input  logic       dac_hi,
  input  logic       ilim100,
  input  logic       ilim150,
  output logic       dron_drive,
  output logic       vr_ready,
  output logic       pwm_en,
  output logic       force_ls,
  output logic       ramp_zero,
  output logic       fault_latched,
  output logic [1:0] fault_cause
);

  seq_state_e   st_q, st_nxt;
  fault_cause_e cause_q, cause_nxt;
  logic         supplies_ok;
  logic         dly_done, bcap_done;
  logic         trip_fast, trip_slow;
  logic         conv_act;

  assign supplies_ok = vcc_ok && vin_ok;
  assign conv_act    = (st_q == ST_SS) || (st_q == ST_RUN);

  vr_seq_timer #(.LIMIT(EN_DLY_TICKS)) u_en_dly (
    .clk  (clk),
    .rst  (rst),
    .clr  ((st_q == ST_POR) || (st_q == ST_DIS)),
    .done (dly_done)
  );

  vr_seq_timer #(.LIMIT(BCAP_TICKS)) u_bcap (
    .clk  (clk),
    .rst  (rst),
    .clr  (st_q != ST_BCAP),
    .done (bcap_done)
  );

  vr_seq_ocp #(.OC_TICKS(OC_DLY_TICKS)) u_ocp (
    .clk       (clk),
    .rst       (rst),
    .act       (conv_act),
    .vout_hi   (vout_hi),
    .dac_hi    (dac_hi),
    .ilim100   (ilim100),
    .ilim150   (ilim150),
    .trip_fast (trip_fast),
    .trip_slow (trip_slow)
  );

  always_comb begin
    st_nxt    = st_q;
    cause_nxt = cause_q;
    unique case (st_q)
      ST_POR:  if (supplies_ok) st_nxt = ST_DIS;
      ST_DIS:  if (en) st_nxt = ST_CAL;
      ST_CAL:  if (cal_done) st_nxt = ST_CFG;
      ST_CFG:  if (cfg_done && dly_done) st_nxt = ST_DRV;
      ST_DRV:  if (drv_ok) st_nxt = boot_zero ? ST_WVID : ST_BCAP;
      ST_WVID: if (vid_set) st_nxt = ST_BCAP;
      ST_BCAP: if (bcap_done) st_nxt = ST_SS;
      ST_SS, ST_RUN: begin
        if (ov_abs || (ov_rel && st_q == ST_RUN)) begin
          st_nxt = ST_OVP; cause_nxt = FC_OVP;
        end else if (trip_fast) begin
          st_nxt = ST_OCP; cause_nxt = FC_OCF;
        end else if (trip_slow) begin
          st_nxt = ST_OCP; cause_nxt = FC_OCS;
        end else if (st_q == ST_SS && ss_done) begin
          st_nxt = ST_RUN;
        end
      end
      ST_OVP, ST_OCP: st_nxt = st_q;
      default: st_nxt = ST_POR;
    endcase
    // exits that override the sequence, lowest priority first
    if (!drv_ok && (st_q inside {ST_WVID, ST_BCAP, ST_SS, ST_RUN})) st_nxt = ST_DIS;
    if (!en && st_q != ST_POR) st_nxt = ST_DIS;
    if (!supplies_ok)          st_nxt = ST_POR;
    if (st_nxt == ST_POR || st_nxt == ST_DIS) cause_nxt = FC_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= ST_POR;
      cause_q       <= FC_NONE;
      dron_drive    <= 1'b0;
      vr_ready      <= 1'b0;
      pwm_en        <= 1'b0;
      force_ls      <= 1'b0;
      ramp_zero     <= 1'b0;
      fault_latched <= 1'b0;
      fault_cause   <= 2'd0;
    end else begin
      st_q          <= st_nxt;
      cause_q       <= cause_nxt;
      dron_drive    <= st_nxt inside {ST_DRV, ST_WVID, ST_BCAP, ST_SS, ST_RUN, ST_OVP};
      vr_ready      <= (st_nxt == ST_RUN) && !uv;
      pwm_en        <= st_nxt inside {ST_SS, ST_RUN};
      force_ls      <= (st_nxt == ST_OVP);
      ramp_zero     <= (st_nxt == ST_OVP);
      fault_latched <= st_nxt inside {ST_OVP, ST_OCP};
      fault_cause   <= cause_nxt;
    end
  end

  // R5
  ready_gate_chk: assert property (@(posedge clk) disable iff (rst)
    vr_ready |-> (pwm_en && dron_drive && !fault_latched));

  // R6
  ovp_out_chk: assert property (@(posedge clk) disable iff (rst)
    ramp_zero |-> (force_ls && dron_drive && fault_latched && !pwm_en && !vr_ready));

  // R7
  fast_trip_chk: assert property (@(posedge clk) disable iff (rst)
    (pwm_en && en && vcc_ok && vin_ok && drv_ok && !ov_abs && !ov_rel &&
     ilim150 && (vout_hi || dac_hi))
    |=> (fault_latched && !dron_drive && fault_cause == 2'd3));

  // R10
  uv_ready_chk: assert property (@(posedge clk) disable iff (rst)
    uv |=> !vr_ready);

  // R11
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_latched && en && vcc_ok && vin_ok) |=> fault_latched);

  // R12
  en_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!dron_drive && !pwm_en && !vr_ready));

endmodule

// File: tb/vr_seq_ctrl_tb.sv
module vr_seq_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int EN_DLY     = 8;
  localparam int BCAP       = 4;
  localparam int OC_DLY     = 6;

  // obs byte: [7:6] cause, [5] latched, [4] ramp_zero, [3] force_ls,
  //           [2] pwm_en, [1] ready, [0] dron_drive
  localparam logic [7:0] O_OFF = 8'h00, O_DRV = 8'h01, O_SS = 8'h05,
                         O_RUN = 8'h07, O_OVP = 8'h79, O_OCF = 8'hE0, O_OCS = 8'hA0;

  typedef struct packed {
    logic       run;
    logic       ova;
    logic       ovr;
    logic       i150;
    logic       uvv;
    logic       vhi;
    logic [7:0] e1;
    logic [7:0] e2;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, O_OVP, O_OVP},  // R6 relative in run
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, O_OVP, O_OVP},  // R6 absolute in run
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, O_OVP, O_OVP},  // R6 absolute in soft start
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, O_SS,  O_SS },  // R6 relative ignored in soft start
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, O_OCF, O_OCF},  // R7 run
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, O_RUN, O_RUN},  // R9 unarmed
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, O_OCF, O_OCF},  // R7 soft start
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, O_SS,  O_RUN},  // R10
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, O_OVP, O_OVP}   // R6 priority
  };

  logic clk = 1'b0;
  logic rst, vcc_ok, vin_ok, en, drv_ok, cal_done, cfg_done, boot_zero, vid_set;
  logic ss_done, ov_abs, ov_rel, uv, vout_hi, dac_hi, ilim100, ilim150;
  logic dron_drive, vr_ready, pwm_en, force_ls, ramp_zero, fault_latched;
  logic [1:0] fault_cause;
  logic [7:0] obs;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign obs = {fault_cause, fault_latched, ramp_zero, force_ls, pwm_en, vr_ready, dron_drive};

  vr_seq_ctrl #(.EN_DLY_TICKS(EN_DLY), .BCAP_TICKS(BCAP), .OC_DLY_TICKS(OC_DLY)) dut_i (
    .clk(clk), .rst(rst), .vcc_ok(vcc_ok), .vin_ok(vin_ok), .en(en), .drv_ok(drv_ok),
    .cal_done(cal_done), .cfg_done(cfg_done), .boot_zero(boot_zero), .vid_set(vid_set),
    .ss_done(ss_done), .ov_abs(ov_abs), .ov_rel(ov_rel), .uv(uv), .vout_hi(vout_hi),
    .dac_hi(dac_hi), .ilim100(ilim100), .ilim150(ilim150), .dron_drive(dron_drive),
    .vr_ready(vr_ready), .pwm_en(pwm_en), .force_ls(force_ls), .ramp_zero(ramp_zero),
    .fault_latched(fault_latched), .fault_cause(fault_cause)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ov_abs = 0; ov_rel = 0; uv = 0; vout_hi = 0; dac_hi = 0; ilim100 = 0; ilim150 = 0;
    ss_done = 0; vid_set = 0; boot_zero = 0; cal_done = 1; cfg_done = 1; drv_ok = 1;
    vcc_ok = 1; vin_ok = 1;
  endtask

  // from anywhere: disable, then start and land in soft start (R4 window)
  task automatic go_ss();
    idle_inputs();
    en = 0;
    tick(1);
    en = 1;
    tick(EN_DLY + BCAP + 3);
    chk("R4 refresh still running", obs, O_DRV);
    tick(1);
    chk("R4 soft start entered", obs, O_SS);
  endtask

  task automatic go_run();
    go_ss();
    ss_done = 1;
    tick(1);
    ss_done = 0;
    chk("R5 ready on ss_done", obs, O_RUN);
  endtask

  function automatic string vtag(input int i);
    case (i)
      4, 6:    return "R7";
      5:       return "R9";
      7:       return "R10";
      default: return "R6";
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    en = 0;
    rst = 1;
    tick(3);
    chk("R1 outputs in reset", obs, O_OFF);
    rst = 0;
    tick(1);
    chk("R1 first cycle after reset", obs, O_OFF);

    // R2 gating by supplies, calibration and configuration
    vin_ok = 0; en = 1;
    tick(40);
    chk("R2 input rail low", obs, O_OFF);
    vin_ok = 1; cal_done = 0;
    tick(40);
    chk("R2 calibration pending", obs, O_OFF);
    cal_done = 1; cfg_done = 0;
    tick(40);
    chk("R2 configuration pending", obs, O_OFF);
    cfg_done = 1;
    tick(1);
    chk("R2 driver enable after configuration", obs, O_DRV);

    // R3 exact enable delay
    en = 0;
    tick(1);
    en = 1;
    tick(EN_DLY + 1);
    chk("R3 driver enable not yet", obs, O_OFF);
    tick(1);
    chk("R3 driver enable on time", obs, O_DRV);

    // R4 zero boot waits for a voltage command
    en = 0;
    tick(1);
    boot_zero = 1; en = 1;
    tick(EN_DLY + 2);
    chk("R4 driver enable raised", obs, O_DRV);
    tick(9);
    chk("R4 waiting for command", obs, O_DRV);
    vid_set = 1;
    tick(1);
    vid_set = 0; boot_zero = 0;
    tick(BCAP);
    chk("R4 refresh after command", obs, O_DRV);
    tick(1);
    chk("R4 soft start after command", obs, O_SS);

    // R5 ready withheld during soft start
    tick(6);
    chk("R5 no ready before ss_done", obs, O_SS);

    // table of fault vectors
    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].run) go_run(); else go_ss();
      ov_abs = VECS[i].ova; ov_rel = VECS[i].ovr; ilim150 = VECS[i].i150;
      uv = VECS[i].uvv; vout_hi = VECS[i].vhi;
      tick(1);
      chk($sformatf("%s vector %0d response", vtag(i), i), obs, VECS[i].e1);
      ov_abs = 0; ov_rel = 0; ilim150 = 0; uv = 0; vout_hi = 0;
      tick(1);
      chk($sformatf("%s vector %0d after release", vtag(i), i), obs, VECS[i].e2);
    end

    // R8 persistence window of the nominal tier
    go_run();
    dac_hi = 1; ilim100 = 1;
    tick(OC_DLY - 1);
    chk("R8 short burst", obs, O_RUN);
    ilim100 = 0;
    tick(1);
    ilim100 = 1;
    tick(OC_DLY - 1);
    chk("R8 count restarted", obs, O_RUN);
    tick(1);
    chk("R8 slow trip", obs, O_OCS);
    ilim100 = 0;
    tick(3);
    chk("R11 slow fault held", obs, O_OCS);
    en = 0;
    tick(1);
    chk("R11 enable clears", obs, O_OFF);

    // R9 sticky arming
    go_ss();
    vout_hi = 1;
    tick(1);
    vout_hi = 0;
    tick(2);
    ilim150 = 1;
    tick(1);
    chk("R9 armed stays armed", obs, O_OCF);
    ilim150 = 0;

    // R11 supply loss clears a latched overvoltage
    go_run();
    ov_rel = 1;
    tick(1);
    ov_rel = 0;
    tick(2);
    chk("R11 overvoltage held", obs, O_OVP);
    vcc_ok = 0;
    tick(1);
    chk("R11 supply loss clears", obs, O_OFF);
    vcc_ok = 1;

    // R12 driver line pulled low, then enable low
    go_run();
    drv_ok = 0;
    tick(1);
    chk("R12 driver line lost", obs, O_OFF);
    drv_ok = 1;
    go_run();
    en = 0;
    tick(1);
    chk("R12 enable low", obs, O_OFF);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule